// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Receiver

This block receives serial words whose shift clock comes from another device. The shift clock and the data line are brought into the system clock domain through synchronizer chains. Each rising edge of the synchronized shift clock captures one data bit, least significant bit first. Once a full word has been captured, it moves from the shift register into a host-readable data register, and a receive-complete flag is raised.

Reception runs only while both the port enable and the continuous-receive enable are high. If either is dropped, the word in progress is discarded and the bit counter goes back to idle. A 9-bit mode adds a ninth bit to each frame, which is reported on its own status output. A word that completes while the previous one is still unread is discarded and sets a sticky overrun flag. That flag is cleared only by dropping the continuous-receive enable. The single-receive enable input exists for compatibility with a master-capable port and does nothing here.

Top module: `sync_slave_rx`

## Requirements
- R1: In 8-bit mode, eight rising edges of the external shift clock capture bits 0..7, least significant bit first. After that the byte appears on `rx_data_o` with `rx_done_o` = 1.
- R2: With `nine_bit_i` = 1, a frame is nine bits. The ninth received bit appears on `rx_bit9_o` and the first eight appear on `rx_data_o`. In 8-bit mode `rx_bit9_o` reads 0.
- R3: While `port_en_i` = 0 or `cont_rx_en_i` = 0, shift clock edges capture nothing and `rx_done_o` does not rise.
- R4: Dropping `cont_rx_en_i` in the middle of a word aborts it. After re-enabling, a complete new word is needed, and bits captured earlier do not appear in it.
- R5: `irq_o` is 1 exactly when `rx_done_o` = 1 and `irq_en_i` = 1.
- R6: A one-cycle `rd_data_i` pulse clears `rx_done_o` on the next cycle, unless a new word completes in that same cycle.
- R7: If a word completes while `rx_done_o` = 1 and no read is pending, `overrun_o` goes to 1. The new word is discarded, and `rx_data_o` and `rx_done_o` keep their values.
- R8: `overrun_o` stays set through reads and further words. It clears one cycle after `cont_rx_en_i` is low.
- R9: `single_rx_en_i` has no effect on any output.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | External shift clock (asynchronous) |
| ser_data_i | input | 1 | Serial data, sampled on shift clock rising edge |
| port_en_i | input | 1 | Port enable |
| cont_rx_en_i | input | 1 | Continuous-receive enable; low clears overrun |
| single_rx_en_i | input | 1 | Single-receive enable, ignored |
| nine_bit_i | input | 1 | 1 = 9-bit frames |
| irq_en_i | input | 1 | Receive-complete interrupt enable |
| rd_data_i | input | 1 | Host read strobe for the data register |
| rx_data_o | output | 8 | Received data byte |
| rx_bit9_o | output | 1 | Ninth received bit (0 in 8-bit mode) |
| overrun_o | output | 1 | Sticky overrun error |
| rx_done_o | output | 1 | Receive-complete flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Every byte value is received in 8-bit mode, and every 9-bit value is received in 9-bit mode. Any bit-order reversal, a dropped or stuck bit, or a misplaced ninth bit therefore shows up on some pattern. During the 8-bit sweep, `single_rx_en_i` follows a data bit, so any dependence on it would corrupt a result. A partial word is followed by a disable, and then a word is sent whose bits differ from the partial prefix; this separates a true abort from a merge of the two. Back-to-back unread words, followed by reads and a toggle of the enable, separate a discarding, sticky overrun from one that overwrites the data or clears on a read.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  localparam int SSRX_DATA_W = 8;
  localparam int SSRX_SYNC   = 2;

  // index of the final bit of a frame
  function automatic int frame_last(input logic nine, input int dw);
    return nine ? dw : dw - 1;
  endfunction
endpackage

// File: rtl/ssrx_sync.sv
module ssrx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/ssrx_shifter.sv
module ssrx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic          sample_i,
  input  logic          din_i,
  input  logic          nine_i,
  output logic          word_done_o,
  output logic [DATA_W:0] word_o
);
  import ssrx_pkg::*;
  localparam int CW = $clog2(DATA_W + 2);

  logic [CW-1:0]   cnt;
  logic [DATA_W:0] acc;
  logic            at_last;

  function automatic logic [DATA_W:0] put_bit(input logic [DATA_W:0] a,
                                              input logic [CW-1:0] idx,
                                              input logic b);
    logic [DATA_W:0] r;
    r = a;
    r[idx] = b;
    return r;
  endfunction

  assign at_last     = (cnt == CW'(frame_last(nine_i, DATA_W)));
  assign word_done_o = active_i && sample_i && at_last;
  assign word_o      = put_bit(acc, cnt, din_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
    end else if (!active_i) begin
      cnt <= '0;
      acc <= '0;
    end else if (sample_i) begin
      if (at_last) begin
        cnt <= '0;
        acc <= '0;
      end else begin
        cnt <= cnt + CW'(1);
        acc <= word_o;
      end
    end
  end
endmodule

// File: rtl/ssrx_holding.sv
module ssrx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done_i,
  input  logic [DATA_W:0]   word_i,
  input  logic              nine_i,
  input  logic              rd_i,
  input  logic              cont_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              done_o,
  output logic              ovr_o
);
  logic collide;
  assign collide = word_done_i && done_o && !rd_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      bit9_o <= 1'b0;
      done_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (collide) begin
        ovr_o <= 1'b1;
      end else if (word_done_i) begin
        data_o <= word_i[DATA_W-1:0];
        bit9_o <= nine_i ? word_i[DATA_W] : 1'b0;
        done_o <= 1'b1;
      end else if (rd_i) begin
        done_o <= 1'b0;
      end
      if (!cont_en_i) ovr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx #(
  parameter int DATA_W      = ssrx_pkg::SSRX_DATA_W,
  parameter int SYNC_STAGES = ssrx_pkg::SSRX_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              port_en_i,
  input  logic              cont_rx_en_i,
  input  logic              single_rx_en_i,
  input  logic              nine_bit_i,
  input  logic              irq_en_i,
  input  logic              rd_data_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit9_o,
  output logic              overrun_o,
  output logic              rx_done_o,
  output logic              irq_o
);
  logic [1:0]      sync_q;
  logic            clk_prev;
  logic            sample_rise;
  logic            rx_active;
  logic            word_done;
  logic [DATA_W:0] word_bits;
  logic            sre_unused;

  assign sre_unused = single_rx_en_i;
  assign rx_active  = port_en_i && cont_rx_en_i;

  ssrx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({ser_clk_i, ser_data_i}), .q_o(sync_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b0;
    else        clk_prev <= sync_q[1];
  end
  assign sample_rise = sync_q[1] && !clk_prev;

  ssrx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .active_i(rx_active), .sample_i(sample_rise), .din_i(sync_q[0]),
    .nine_i(nine_bit_i), .word_done_o(word_done), .word_o(word_bits)
  );

  ssrx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .word_done_i(word_done), .word_i(word_bits), .nine_i(nine_bit_i),
    .rd_i(rd_data_i), .cont_en_i(cont_rx_en_i),
    .data_o(rx_data_o), .bit9_o(rx_bit9_o), .done_o(rx_done_o), .ovr_o(overrun_o)
  );

  assign irq_o = rx_done_o && irq_en_i;
endmodule

// File: rtl/ssrx_checker.sv
module ssrx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_en_i,
  input logic              cont_rx_en_i,
  input logic              irq_en_i,
  input logic              rd_data_i,
  input logic              word_done,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_done_o,
  input logic              overrun_o,
  input logic              irq_o
);
  p_idle_no_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en_i && cont_rx_en_i) |-> !word_done);

  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (rx_done_o && irq_en_i));

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_i && !word_done) |=> !rx_done_o);

  p_unread_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_o && !rd_data_i) |=> ($stable(rx_data_o) && rx_done_o));

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && cont_rx_en_i) |=> overrun_o);

  p_ovr_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_rx_en_i |=> !overrun_o);
endmodule

bind sync_slave_rx ssrx_checker #(.DATA_W(DATA_W)) u_ssrx_chk (
  .clk(clk), .rst_n(rst_n), .port_en_i(port_en_i), .cont_rx_en_i(cont_rx_en_i),
  .irq_en_i(irq_en_i), .rd_data_i(rd_data_i), .word_done(word_done),
  .rx_data_o(rx_data_o), .rx_done_o(rx_done_o), .overrun_o(overrun_o), .irq_o(irq_o)
);

// File: tb/sync_slave_rx_bench.sv
module sync_slave_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0;
  logic port_en = 1'b0, cont_en = 1'b0, single_en = 1'b0;
  logic nine = 1'b0, irq_en = 1'b0, rd = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit9, overrun, rx_done, irq;
  int tests = 0, fails = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  sync_slave_rx u_sync_slave_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
    .port_en_i(port_en), .cont_rx_en_i(cont_en), .single_rx_en_i(single_en),
    .nine_bit_i(nine), .irq_en_i(irq_en), .rd_data_i(rd),
    .rx_data_o(rx_data), .rx_bit9_o(rx_bit9), .overrun_o(overrun),
    .rx_done_o(rx_done), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [8:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      ser_data = v[i];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 data", int'(rx_data), 0);
    chk("R10 flags", int'({rx_bit9, overrun, rx_done, irq}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    port_en = 1'b1;
    cont_en = 1'b1;

    // R1 / R2 / R9 / R6: full byte sweep, single-receive enable wiggled
    for (int v = 0; v < 256; v++) begin
      single_en = v[1];
      send_bits(9'(v), 8);
      chk("R1 data", int'(rx_data), v);
      chk("R1 done", int'(rx_done), 1);
      chk("R2 bit9 zero in 8-bit", int'(rx_bit9), 0);
      do_read();
      chk("R6 read clears", int'(rx_done), 0);
    end
    single_en = 1'b0;

    // R5: interrupt gating
    send_bits(9'h05A, 8);
    chk("R5 irq disabled", int'(irq), 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R5 irq enabled", int'(irq), 1);
    do_read();
    chk("R5 irq after read", int'(irq), 0);
    irq_en = 1'b0;

    // R2: full 9-bit sweep
    nine = 1'b1;
    for (int v = 0; v < 512; v++) begin
      send_bits(9'(v), 9);
      chk("R2 data", int'(rx_data), v & 255);
      chk("R2 bit9", int'(rx_bit9), v >> 8);
      do_read();
    end
    nine = 1'b0;

    // R3: disabled port / receive enable
    port_en = 1'b0;
    send_bits(9'h0FF, 8);
    chk("R3 port off", int'(rx_done), 0);
    port_en = 1'b1;
    cont_en = 1'b0;
    send_bits(9'h0FF, 8);
    chk("R3 rx off", int'(rx_done), 0);
    cont_en = 1'b1;
    @(negedge clk);

    // R4: abort mid-word
    send_bits(9'h00F, 4);
    cont_en = 1'b0;
    repeat (3) @(negedge clk);
    cont_en = 1'b1;
    @(negedge clk);
    send_bits(9'h0A5, 8);
    chk("R4 fresh word", int'(rx_data), 8'hA5);
    chk("R4 done", int'(rx_done), 1);
    do_read();

    // R7 / R8: overrun
    send_bits(9'h03C, 8);
    chk("R7 no overrun yet", int'(overrun), 0);
    send_bits(9'h0C3, 8);
    chk("R7 overrun set", int'(overrun), 1);
    chk("R7 data kept", int'(rx_data), 8'h3C);
    chk("R7 done kept", int'(rx_done), 1);
    do_read();
    chk("R8 sticky after read", int'(overrun), 1);
    send_bits(9'h011, 8);
    chk("R8 new word accepted", int'(rx_data), 8'h11);
    chk("R8 still sticky", int'(overrun), 1);
    do_read();
    cont_en = 1'b0;
    @(negedge clk);
    chk("R8 cleared by enable low", int'(overrun), 0);
    cont_en = 1'b1;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule